// File: doc/BRIEF.md
# Double-Buffered Channel Code Bank

This block holds eight channels of 8-bit output codes, each behind two registers: a staging register that commands may fill quietly, and an active register whose value drives the channel. A 16-bit command word, qualified by a single-cycle execute strobe, selects one of eight operations. Some operations touch one addressed channel. Others act on all channels at once: clear, load every channel with the same byte, copy all staging to active, and enter a low-power state where a per-channel mask turns individual output buffers off.

An active-low load pin gives a hardware route to the same staging-to-active copy. The pin is synchronized to the clock. While it is held low, every active register follows its staging register each cycle, so a staging write shows on the output at the same edge. One command also asks the serial front end to change the edge on which it shifts data out. The block reports that request as a one-cycle pulse plus a held phase level.

Top module: `dbuf_chan_ctrl`

## Requirements
- R1: After reset every active code is 0, every channel enable is 1, the shutdown flag is 0, the phase level is 0 and the phase request is 0.
- R2: The command word is split as bits [7:0] data, [10:8] opcode, [13:11] channel address, with bits [15:14] ignored. A command acts only at a clock edge where the execute strobe is high. With the strobe low and the load pin high, no output changes.
- R3: Opcode 000 changes no staging register, active register, enable or shutdown state.
- R4: Opcode 001 zeroes every staging and active register, sets every channel enable and clears the shutdown flag.
- R5: Opcode 010 sets the shutdown flag and makes channel i's enable equal to data bit i, so data 0x00 disables every channel.
- R6: Opcode 011 copies every staging register to its active register, latches address bit 13 as the phase level, and pulses the phase request high for exactly the one cycle after the command.
- R7: Opcode 100 writes the data byte into all staging and active registers, sets every enable and clears the shutdown flag.
- R8: Opcode 101 writes the data byte into the addressed staging register only. No active register, enable or shutdown state changes.
- R9: Opcode 110 writes the data byte into the addressed staging and active registers, leaves other channels unchanged, sets every enable and clears the shutdown flag.
- R10: Opcode 111 copies every staging register to its active register and does not leave shutdown.
- R11: From the third clock edge after the load pin goes low, and while it stays low, each active register equals its staging register after every edge, including a staging write made at that same edge.
- R12: While in shutdown, opcodes 000, 011, 101 and 111 leave the shutdown flag and every channel enable unchanged. Only opcodes 001, 100 and 110 leave shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 16 | Command word: pad, address, opcode, data |
| cmd_exec | input | 1 | Execute strobe, one command per high cycle |
| load_n | input | 1 | Asynchronous active-low load pin, level-sensitive |
| act_code | output | 64 | Active codes, channel i at bits [8i+7:8i] |
| chan_en | output | 8 | Per-channel output buffer enable |
| shdn_flag | output | 1 | High while the block is in shutdown |
| phase_req | output | 1 | One-cycle request to the serial front end to change output phase |
| phase_sel | output | 1 | Held output phase level, 0 after reset |

## Verification
Random command words with random addresses, data and pad bits, applied with a strobe that is sometimes held low, show whether the opcode and address fields are decoded from the right bit positions and whether the pad bits truly have no effect. Staging-only writes that are followed later by a copy, either by command or by the load pin, tell a design that writes the active register too early apart from one that forgets the staging value. Writes issued while the load pin is held low show whether the active register picks up the new staging value at the same edge or one cycle late. Shutdown entered with mixed and all-zero masks, then followed by non-waking commands, shows which opcodes are allowed to clear the mask.

// File: rtl/dbuf_chan_pkg.sv
package dbuf_chan_pkg;

   localparam int PAD_W = 2;
   localparam int OP_W  = 3;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE       = 3'b000,
      OP_WIPE       = 3'b001,
      OP_SLEEP      = 3'b010,
      OP_PHASE_COPY = 3'b011,
      OP_FILL_ALL   = 3'b100,
      OP_STAGE      = 3'b101,
      OP_STAGE_ACT  = 3'b110,
      OP_COPY_ALL   = 3'b111
   } op_e;

   typedef struct packed {
      logic wipe;
      logic sleep;
      logic wake;
      logic copy_all;
      logic phase_set;
      logic phase_val;
   } glb_ctl_t;

endpackage

// File: rtl/dbuf_cmd_decode.sv
module dbuf_cmd_decode
   import dbuf_chan_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W+OP_W+CODE_W-1:0] word,
   input  logic                          exec,
   output glb_ctl_t                      glb,
   output logic [NUM_CH-1:0]             stg_we,
   output logic [NUM_CH-1:0]             act_we,
   output logic [CODE_W-1:0]             data
);

   localparam int OP_LSB   = CODE_W;
   localparam int ADDR_LSB = CODE_W + OP_W;

   op_e               op;
   logic [ADDR_W-1:0] addr;
   logic              fill_all;
   logic              one_stage;
   logic              one_act;

   assign data = word[CODE_W-1:0];
   assign op   = op_e'(word[OP_LSB +: OP_W]);
   assign addr = word[ADDR_LSB +: ADDR_W];

   always_comb begin
      glb           = '0;
      glb.phase_val = addr[ADDR_W-1];
      fill_all      = 1'b0;
      one_stage     = 1'b0;
      one_act       = 1'b0;
      if (exec) begin
         case (op)
            OP_IDLE:       ;
            OP_WIPE:       begin glb.wipe = 1'b1; glb.wake = 1'b1; end
            OP_SLEEP:      glb.sleep = 1'b1;
            OP_PHASE_COPY: begin glb.copy_all = 1'b1; glb.phase_set = 1'b1; end
            OP_FILL_ALL:   begin fill_all = 1'b1; glb.wake = 1'b1; end
            OP_STAGE:      one_stage = 1'b1;
            OP_STAGE_ACT:  begin one_stage = 1'b1; one_act = 1'b1; glb.wake = 1'b1; end
            OP_COPY_ALL:   glb.copy_all = 1'b1;
            default:       ;
         endcase
      end
   end

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
      logic hit;
      assign hit        = (addr == ADDR_W'(gi));
      assign stg_we[gi] = fill_all | (one_stage & hit);
      assign act_we[gi] = fill_all | (one_act & hit);
   end

endmodule

// File: rtl/dbuf_pin_sync.sv
module dbuf_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic active
);

   if (STAGES == 0) begin : g_direct
      assign active = ~pin_n;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], pin_n} & {STAGES{1'b1}};
      end
      assign active = ~chain_q[STAGES-1];
   end

endmodule

// File: rtl/dbuf_chan_slot.sv
module dbuf_chan_slot #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              stg_we,
   input  logic              act_we,
   input  logic              copy,
   input  logic [CODE_W-1:0] data,
   output logic [CODE_W-1:0] act_q
);

   logic [CODE_W-1:0] stg_q;
   logic [CODE_W-1:0] stg_nx;
   logic [CODE_W-1:0] act_nx;

   always_comb begin
      if (wipe)        stg_nx = '0;
      else if (stg_we) stg_nx = data;
      else             stg_nx = stg_q;
   end

   always_comb begin
      if (wipe)        act_nx = '0;
      else if (act_we) act_nx = data;
      else if (copy)   act_nx = stg_nx;
      else             act_nx = act_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
         act_q <= '0;
      end else begin
         stg_q <= stg_nx;
         act_q <= act_nx;
      end
   end

endmodule

// File: rtl/dbuf_chan_ctrl.sv
module dbuf_chan_ctrl
   import dbuf_chan_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int CODE_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [PAD_W+ADDR_W+OP_W+CODE_W-1:0] cmd_word,
   input  logic                                cmd_exec,
   input  logic                                load_n,
   output logic [NUM_CH*CODE_W-1:0]            act_code,
   output logic [NUM_CH-1:0]                   chan_en,
   output logic                                shdn_flag,
   output logic                                phase_req,
   output logic                                phase_sel
);

   localparam int BODY_W = ADDR_W + OP_W + CODE_W;
   localparam int WORD_W = PAD_W + BODY_W;

   if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("NUM_CH must be between 1 and 2**ADDR_W");
   end
   if (CODE_W < NUM_CH) begin : g_bad_code
      $error("CODE_W must cover one mask bit per channel");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   glb_ctl_t          glb;
   logic [NUM_CH-1:0] stg_we;
   logic [NUM_CH-1:0] act_we;
   logic [CODE_W-1:0] data;
   logic              load_act;
   logic              unused_pad;

   assign unused_pad = ^cmd_word[WORD_W-1:BODY_W];

   dbuf_cmd_decode #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W),
      .ADDR_W (ADDR_W)
   ) dec_i (
      .word   (cmd_word[BODY_W-1:0]),
      .exec   (cmd_exec),
      .glb    (glb),
      .stg_we (stg_we),
      .act_we (act_we),
      .data   (data)
   );

   dbuf_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (load_n),
      .active (load_act)
   );

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      dbuf_chan_slot #(
         .CODE_W (CODE_W)
      ) slot_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .wipe   (glb.wipe),
         .stg_we (stg_we[gi]),
         .act_we (act_we[gi]),
         .copy   (glb.copy_all | load_act),
         .data   (data),
         .act_q  (act_code[gi*CODE_W +: CODE_W])
      );
   end

   if (CODE_W > NUM_CH) begin : g_mask_spare
      logic unused_mask_bits;
      assign unused_mask_bits = ^data[CODE_W-1:NUM_CH];
   end

   // off_q bit set means the channel buffer is off; reset value 0 keeps all on
   logic [NUM_CH-1:0] off_q;
   logic              sleep_q;
   logic              preq_q;
   logic              psel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         sleep_q <= 1'b0;
         preq_q  <= 1'b0;
         psel_q  <= 1'b0;
      end else begin
         preq_q <= glb.phase_set;
         if (glb.phase_set) psel_q <= glb.phase_val;
         if (glb.wake) begin
            off_q   <= '0;
            sleep_q <= 1'b0;
         end else if (glb.sleep) begin
            off_q   <= ~data[NUM_CH-1:0];
            sleep_q <= 1'b1;
         end
      end
   end

   assign chan_en   = ~off_q;
   assign shdn_flag = sleep_q;
   assign phase_req = preq_q;
   assign phase_sel = psel_q;

endmodule

// File: rtl/dbuf_chan_ctrl_chk.sv
module dbuf_chan_ctrl_chk #(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W+CODE_W+4:0]   cmd_word,
   input logic                       cmd_exec,
   input logic                       load_act,
   input logic [NUM_CH*CODE_W-1:0]   act_code,
   input logic [NUM_CH-1:0]          chan_en,
   input logic                       shdn_flag,
   input logic                       phase_req,
   input logic                       phase_sel
);

   logic [2:0] op;
   assign op = cmd_word[CODE_W +: 3];

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_exec && !load_act) |=> ($stable(act_code) && $stable(chan_en) && $stable(shdn_flag)));

   // R3
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_exec && op == 3'b000 && !load_act) |=> ($stable(act_code) && $stable(chan_en) && $stable(shdn_flag)));

   // R4
   wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_exec && op == 3'b001) |=> (act_code == '0 && chan_en == '1 && !shdn_flag));

   // R5
   sleep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_exec && op == 3'b010) |=> (shdn_flag && chan_en == $past(cmd_word[NUM_CH-1:0])));

   // R6
   phase_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_req |-> ($past(cmd_exec) && $past(op) == 3'b011 && phase_sel == $past(cmd_word[CODE_W+3+ADDR_W-1])));

   // R6
   phase_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_req |=> (!phase_req || ($past(cmd_exec) && $past(op) == 3'b011)));

   // R8
   stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_exec && op == 3'b101 && !load_act) |=> $stable(act_code));

   // R12
   sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_flag && cmd_exec && (op == 3'b000 || op == 3'b011 || op == 3'b101 || op == 3'b111))
      |=> (shdn_flag && $stable(chan_en)));

endmodule

bind dbuf_chan_ctrl dbuf_chan_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_word  (cmd_word),
   .cmd_exec  (cmd_exec),
   .load_act  (load_act),
   .act_code  (act_code),
   .chan_en   (chan_en),
   .shdn_flag (shdn_flag),
   .phase_req (phase_req),
   .phase_sel (phase_sel)
);

// File: tb/dbuf_chan_ctrl_tb.sv
module dbuf_chan_ctrl_tb_top;

   localparam int NCH = 8;
   localparam int CW  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       cmd_word = '0;
   logic              cmd_exec = 1'b0;
   logic              load_n = 1'b1;
   logic [NCH*CW-1:0] act_code;
   logic [NCH-1:0]    chan_en;
   logic              shdn_flag;
   logic              phase_req;
   logic              phase_sel;

   always #2 clk = ~clk;

   dbuf_chan_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_word  (cmd_word),
      .cmd_exec  (cmd_exec),
      .load_n    (load_n),
      .act_code  (act_code),
      .chan_en   (chan_en),
      .shdn_flag (shdn_flag),
      .phase_req (phase_req),
      .phase_sel (phase_sel)
   );

   // reference model
   logic [CW-1:0]  m_stg [NCH];
   logic [CW-1:0]  m_act [NCH];
   logic [NCH-1:0] m_off;
   logic           m_shdn;
   logic           m_preq;
   logic           m_psel;
   logic           m_transp;

   int vectors = 0;
   int misses  = 0;
   bit done    = 0;

   function automatic logic [15:0] mk(input logic [2:0] a, input logic [2:0] op,
                                      input logic [7:0] d, input logic [1:0] pad = 2'b00);
      return {pad, a, op, d};
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [NCH*CW-1:0] exp_codes();
      logic [NCH*CW-1:0] v;
      for (int i = 0; i < NCH; i++) v[i*CW +: CW] = m_act[i];
      return v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NCH; i++) begin m_stg[i] = '0; m_act[i] = '0; end
      m_off = '0; m_shdn = 0; m_preq = 0; m_psel = 0; m_transp = 0;
   endtask

   task automatic model_apply(input logic [15:0] w, input logic ex);
      logic [2:0] a;
      logic [2:0] op;
      logic [7:0] d;
      a = w[13:11]; op = w[10:8]; d = w[7:0];
      m_preq = 0;
      if (ex) begin
         case (op)
            3'd1: begin
               for (int i = 0; i < NCH; i++) begin m_stg[i] = '0; m_act[i] = '0; end
               m_off = '0; m_shdn = 0;
            end
            3'd2: begin m_off = ~d; m_shdn = 1; end
            3'd3: begin
               for (int i = 0; i < NCH; i++) m_act[i] = m_stg[i];
               m_psel = a[2]; m_preq = 1;
            end
            3'd4: begin
               for (int i = 0; i < NCH; i++) begin m_stg[i] = d; m_act[i] = d; end
               m_off = '0; m_shdn = 0;
            end
            3'd5: m_stg[a] = d;
            3'd6: begin m_stg[a] = d; m_act[a] = d; m_off = '0; m_shdn = 0; end
            3'd7: for (int i = 0; i < NCH; i++) m_act[i] = m_stg[i];
            default: ;
         endcase
      end
      if (m_transp) for (int i = 0; i < NCH; i++) m_act[i] = m_stg[i];
   endtask

   task automatic compare(input string req);
      logic [NCH*CW-1:0] ec;
      ec = exp_codes();
      vectors++;
      if (act_code !== ec || chan_en !== ~m_off || shdn_flag !== m_shdn ||
          phase_req !== m_preq || phase_sel !== m_psel) begin
         misses++;
         $display("FAIL %s: act=%h en=%b sd=%b preq=%b psel=%b expected act=%h en=%b sd=%b preq=%b psel=%b",
                  req, act_code, chan_en, shdn_flag, phase_req, phase_sel,
                  ec, ~m_off, m_shdn, m_preq, m_psel);
      end
   endtask

   task automatic step(input logic [15:0] w, input logic ex, input string req = "");
      @(negedge clk);
      cmd_word = w;
      cmd_exec = ex;
      @(posedge clk);
      #1;
      cmd_exec = 1'b0;
      model_apply(w, ex);
      if (req != "")  compare(req);
      else if (ex)    compare(req_of(w[10:8]));
      else            compare("R2");
   endtask

   // R11: pin passes two sync flops, so copying starts at the third edge
   task automatic set_load(input logic v);
      @(negedge clk);
      load_n = v;
      repeat (3) @(posedge clk);
      #1;
      m_preq   = 0;
      m_transp = !v;
      if (m_transp) for (int i = 0; i < NCH; i++) m_act[i] = m_stg[i];
      compare("R11");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: run still busy (actual hung, expected finished)");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd24681));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      compare("R1");

      // R2: strobe low, a fill command has no effect
      step(mk(3'd0, 3'd4, 8'hC3), 1'b0, "R2");
      // R7 broadcast, then R8 staging only with pad bits set (R2)
      step(mk(3'd2, 3'd4, 8'h11), 1'b1);
      step(mk(3'd5, 3'd5, 8'h9E, 2'b11), 1'b1, "R2");
      step(mk(3'd0, 3'd7, 8'h00), 1'b1, "R10");
      // R9 single channel both registers
      step(mk(3'd7, 3'd6, 8'hF0), 1'b1);
      step(mk(3'd1, 3'd5, 8'h42), 1'b1, "R8");
      // R6 phase to rising, then back
      step(mk(3'd4, 3'd3, 8'h00), 1'b1, "R6");
      step(mk(3'd0, 3'd0, 8'h00), 1'b0, "R6");
      step(mk(3'd3, 3'd3, 8'hFF), 1'b1, "R6");
      // R5 mixed mask, R12 persistence
      step(mk(3'd0, 3'd2, 8'hA5), 1'b1, "R5");
      step(mk(3'd6, 3'd5, 8'h77), 1'b1, "R12");
      step(mk(3'd0, 3'd7, 8'h00), 1'b1, "R12");
      step(mk(3'd0, 3'd3, 8'h00), 1'b1, "R12");
      step(mk(3'd0, 3'd0, 8'h55), 1'b1, "R12");
      step(mk(3'd2, 3'd6, 8'h3C), 1'b1, "R9");
      // R5 all-zero mask, R4 wipe wakes
      step(mk(3'd0, 3'd2, 8'h00), 1'b1, "R5");
      step(mk(3'd4, 3'd5, 8'h81), 1'b1, "R8");
      step(mk(3'd0, 3'd1, 8'hFF), 1'b1, "R4");
      // R11 transparency and same-edge staging write
      step(mk(3'd3, 3'd5, 8'h5A), 1'b1, "R8");
      set_load(1'b0);
      step(mk(3'd6, 3'd5, 8'hE7), 1'b1, "R11");
      step(mk(3'd0, 3'd4, 8'h2B), 1'b1, "R11");
      step(mk(3'd1, 3'd5, 8'h19), 1'b1, "R11");
      set_load(1'b1);
      step(mk(3'd1, 3'd5, 8'hD2), 1'b1, "R8");

      for (int n = 0; n < 600; n++) begin
         if (($urandom % 40) == 0) set_load($urandom % 2 == 0);
         else step(16'($urandom), ($urandom % 5) != 0);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule